// File: doc/BRIEF.md
# Configuration Capability Chain Search

This block locates a requested capability inside one function's configuration space. Features may sit at any offset. The block therefore never assumes a location: it follows the linked chain of capability headers from the head of the list until the capability ID matches, the chain ends, or the chain proves to be malformed. One engine serves both the standard list, which sits in the first 256 bytes, and the extended list, which sits in the region up to 4 KB.

A caller issues a search by pulsing `cmd_start` with the wanted ID in `cmd_id` and the list selected by `cmd_ext`. The block then reads dwords one at a time from a configuration register store through `rd_req`/`rd_addr`. The store answers with `rd_valid`/`rd_data` after any delay. When the search ends, the block pulses `done` for one cycle. It reports the result on `found`, `offset` and `error`, and these outputs hold until the next search ends.

Top module: `cap_walker`

## Requirements
- R1: Standard search. The head pointer is bits 7:0 of the dword at byte offset 0x34. In each standard header the ID is in bits 7:0 and the next pointer is in bits 15:8. When `cmd_id[7:0]` matches a header's ID, the block pulses `done` with `found`=1, `error`=0 and `offset` equal to that header's byte offset.
- R2: Extended search. The search starts with the header at byte offset 0x100. In each extended header the ID is in bits 15:0, a version is in bits 19:16 and the next pointer is in bits 31:20. A match compares all 16 ID bits, and the version bits have no effect on the result.
- R3: The two low bits of every pointer are forced to zero before use, so every `rd_addr` is dword aligned.
- R4: A next pointer of zero, or a standard head pointer of zero, ends the search with `done`=1, `found`=0, `error`=0 and `offset`=0. An all-zero header at 0x100 means the extended list is empty and ends the search in the same way.
- R5: A nonzero pointer below 0x40 on the standard list, or below 0x100 on the extended list, ends the search with `error`=1, `found`=0 and `offset`=0.
- R6: A search that has examined 48 standard headers, or 960 extended headers, without a match or an end of list stops with `error`=1. The block makes no further header read after that header.
- R7: At most one read is outstanding. `rd_req` is high for one cycle per read, and the block issues no new request until `rd_valid` has returned the previous word.
- R8: A `cmd_start` pulse that arrives while a search is in progress is ignored and does not change the running search.
- R9: `done` is a one-cycle pulse. `found`, `error` and `offset` change only in the cycle in which `done` is high, and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-search strobe |
| cmd_ext | input | 1 | 1 selects the extended list, 0 selects the standard list |
| cmd_id | input | 16 | Capability ID to find (the standard list uses bits 7:0) |
| rd_req | output | 1 | Read request, one cycle per read |
| rd_addr | output | 12 | Byte offset of the dword to read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| done | output | 1 | Search complete, one-cycle pulse |
| found | output | 1 | The capability was found |
| error | output | 1 | The list is malformed or the step limit was reached |
| offset | output | 12 | Byte offset of the matching header |

## Verification
The first `rd_req` is high in the cycle after the edge that accepts `cmd_start`. After each `rd_valid` edge, either the next `rd_req` follows one cycle later, or `done` rises at that same edge and the results change together with it. The bench's store model adds a delay that depends on the address. The bench therefore does not count a fixed latency: it samples on the falling edge, waits for the cycle in which `done` is high, checks the results there and checks again one cycle later that the pulse has ended. It counts the requests in each search, which confirms the number of headers visited and the step limit.

// File: rtl/cw_pkg.sv
package cw_pkg;
    localparam int CFG_AW = 12;

    localparam logic [CFG_AW-1:0] STD_HEAD_LOC = 12'h034;
    localparam logic [CFG_AW-1:0] EXT_HEAD_LOC = 12'h100;
    localparam logic [CFG_AW-1:0] STD_FLOOR    = 12'h040;
    localparam logic [CFG_AW-1:0] EXT_FLOOR    = 12'h100;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT
    } walk_state_e;

    typedef struct packed {
        walk_state_e       st;
        logic              ext;
        logic [15:0]       id;
        logic [CFG_AW-1:0] addr;
        logic              head;
        logic              first;
        logic              done;
        logic              found;
        logic              err;
        logic [CFG_AW-1:0] off;
    } walk_regs_t;
endpackage

// File: rtl/cw_hdr_decode.sv
module cw_hdr_decode
    import cw_pkg::*;
(
    input  logic [31:0]       word,
    input  logic              is_ext,
    input  logic              is_head,
    output logic [15:0]       cap_id,
    output logic [CFG_AW-1:0] next_ptr,
    output logic              all_zero
);
    always_comb begin
        if (is_head) begin
            cap_id   = 16'h0000;
            next_ptr = {4'h0, word[7:2], 2'b00};
        end else if (is_ext) begin
            cap_id   = word[15:0];
            next_ptr = {word[31:22], 2'b00};
        end else begin
            cap_id   = {8'h00, word[7:0]};
            next_ptr = {4'h0, word[15:10], 2'b00};
        end
        all_zero = (word == 32'h0);
    end
endmodule

// File: rtl/cw_step_guard.sv
module cw_step_guard #(
    parameter int STD_LIMIT = 48,
    parameter int EXT_LIMIT = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic use_ext,
    output logic last
);
    localparam int CW = $clog2(EXT_LIMIT + 1);
    localparam logic [CW-1:0] STD_LAST = CW'(STD_LIMIT - 1);
    localparam logic [CW-1:0] EXT_LAST = CW'(EXT_LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = cnt_q + 1'b1;
        end
        last = (cnt_q == (use_ext ? EXT_LAST : STD_LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cap_walker.sv
module cap_walker
    import cw_pkg::*;
#(
    parameter int STD_LIMIT = 48,
    parameter int EXT_LIMIT = 960
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_ext,
    input  logic [15:0]       cmd_id,
    output logic              rd_req,
    output logic [CFG_AW-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              done,
    output logic              found,
    output logic              error,
    output logic [CFG_AW-1:0] offset
);
    walk_regs_t d, q;

    logic [15:0]       hdr_id;
    logic [CFG_AW-1:0] hdr_next;
    logic              hdr_zero;
    logic              step_last;
    logic              step_clr;
    logic              step_adv;
    logic              fin;
    logic              fin_found;
    logic              fin_err;
    logic              id_hit;
    logic [CFG_AW-1:0] floor_v;

    cw_hdr_decode dec_i (
        .word     (rd_data),
        .is_ext   (q.ext),
        .is_head  (q.head),
        .cap_id   (hdr_id),
        .next_ptr (hdr_next),
        .all_zero (hdr_zero)
    );

    cw_step_guard #(
        .STD_LIMIT (STD_LIMIT),
        .EXT_LIMIT (EXT_LIMIT)
    ) guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (step_clr),
        .advance (step_adv),
        .use_ext (q.ext),
        .last    (step_last)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        step_clr  = 1'b0;
        step_adv  = 1'b0;
        fin       = 1'b0;
        fin_found = 1'b0;
        fin_err   = 1'b0;
        floor_v   = q.ext ? EXT_FLOOR : STD_FLOOR;
        id_hit    = q.ext ? (hdr_id == q.id) : (hdr_id[7:0] == q.id[7:0]);

        case (q.st)
            S_IDLE: begin
                if (cmd_start) begin
                    d.st     = S_REQ;
                    d.ext    = cmd_ext;
                    d.id     = cmd_id;
                    d.head   = !cmd_ext;
                    d.first  = cmd_ext;
                    d.addr   = cmd_ext ? EXT_HEAD_LOC : STD_HEAD_LOC;
                    step_clr = 1'b1;
                end
            end
            S_REQ: begin
                d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rd_valid) begin
                    if (q.head) begin
                        if (hdr_next == '0) begin
                            fin = 1'b1;
                        end else if (hdr_next < floor_v) begin
                            fin     = 1'b1;
                            fin_err = 1'b1;
                        end else begin
                            d.st   = S_REQ;
                            d.addr = hdr_next;
                            d.head = 1'b0;
                        end
                    end else if (q.first && hdr_zero) begin
                        fin = 1'b1;
                    end else if (id_hit) begin
                        fin       = 1'b1;
                        fin_found = 1'b1;
                    end else if (hdr_next == '0) begin
                        fin = 1'b1;
                    end else if (hdr_next < floor_v || step_last) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        d.st     = S_REQ;
                        d.addr   = hdr_next;
                        d.first  = 1'b0;
                        step_adv = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            d.st    = S_IDLE;
            d.done  = 1'b1;
            d.found = fin_found;
            d.err   = fin_err;
            d.off   = fin_found ? q.addr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_req  = (q.st == S_REQ);
    assign rd_addr = q.addr;
    assign done    = q.done;
    assign found   = q.found;
    assign error   = q.err;
    assign offset  = q.off;
endmodule

// File: rtl/cw_checker.sv
module cw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [11:0] rd_addr,
    input logic        done,
    input logic        found,
    input logic        error,
    input logic [11:0] offset
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (rd_req) begin
            pend_q <= 1'b1;
        end else if (rd_valid) begin
            pend_q <= 1'b0;
        end
    end

    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pend_q);

    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(found) && $stable(error) && $stable(offset)));

    a_r5_error_excludes_found: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> !found);

    a_r1_found_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (offset >= 12'h040 && offset[1:0] == 2'b00));
endmodule

bind cap_walker cw_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .done     (done),
    .found    (found),
    .error    (error),
    .offset   (offset)
);

// File: tb/cap_walker_tb_top.sv
`timescale 1ns/1ps
module cap_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_ext = 1'b0;
    logic [15:0] cmd_id = 16'h0;
    logic        rd_req;
    logic [11:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = 32'h0;
    logic        done, found, error;
    logic [11:0] offset;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int overlap = 0;
    int wait_cnt = 0;
    logic [11:0] pend_addr = '0;
    logic [31:0] mem [1024];

    always #10 clk = ~clk;

    cap_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ext(cmd_ext),
        .cmd_id(cmd_id), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .found(found), .error(error), .offset(offset)
    );

    // configuration store model: delay of 1..4 cycles depending on address
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req) begin
            reads <= reads + 1;
            if (wait_cnt != 0) overlap <= overlap + 1;
            pend_addr <= rd_addr;
            wait_cnt  <= 1 + int'(rd_addr[3:2]);
        end else if (wait_cnt == 1) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[pend_addr[11:2]];
            wait_cnt <= 0;
        end else if (wait_cnt > 1) begin
            wait_cnt <= wait_cnt - 1;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    endtask

    task automatic put_head(input logic [7:0] p);
        mem[12'h034 >> 2] = {24'h0, p};
    endtask

    task automatic put_std(input logic [11:0] at, input logic [7:0] id, input logic [7:0] nxt);
        mem[at >> 2] = {16'hA5A5, nxt, id};
    endtask

    task automatic put_ext(input logic [11:0] at, input logic [15:0] id, input logic [3:0] ver, input logic [11:0] nxt);
        mem[at >> 2] = {nxt, ver, id};
    endtask

    task automatic pulse_start(input logic ext, input logic [15:0] id);
        @(negedge clk);
        cmd_start = 1'b1; cmd_ext = ext; cmd_id = id;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic walk(input string req, input logic ext, input logic [15:0] id,
                        input logic exp_found, input logic exp_err, input logic [11:0] exp_off,
                        input int exp_reads);
        int n;
        reads = 0;
        overlap = 0;
        pulse_start(ext, id);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, "done seen", {31'h0, done}, 32'h1);
        check(req, "found", {31'h0, found}, {31'h0, exp_found});
        check(req, "error", {31'h0, error}, {31'h0, exp_err});
        check(req, "offset", {20'h0, offset}, {20'h0, exp_off});
        if (exp_reads >= 0) check(req, "read count", reads, exp_reads);
        check("R7", "overlapping reads", overlap, 0);
        @(negedge clk);
        check("R9", "done one cycle", {31'h0, done}, 32'h0);
        check("R9", "found held", {31'h0, found}, {31'h0, exp_found});
    endtask

    task automatic t_reset();
        check("R9", "reset done", {31'h0, done}, 32'h0);
        check("R9", "reset found", {31'h0, found}, 32'h0);
        check("R9", "reset error", {31'h0, error}, 32'h0);
        check("R9", "reset offset", {20'h0, offset}, 32'h0);
        check("R7", "reset rd_req", {31'h0, rd_req}, 32'h0);
    endtask

    task automatic t_std_find();
        clear_mem();
        put_head(8'h40);
        put_std(12'h040, 8'h01, 8'h5C);
        put_std(12'h05C, 8'h05, 8'h70);
        put_std(12'h070, 8'h10, 8'h00);
        walk("R1", 1'b0, 16'hFF10, 1'b1, 1'b0, 12'h070, 4);
        walk("R1", 1'b0, 16'h0005, 1'b1, 1'b0, 12'h05C, 3);
    endtask

    task automatic t_std_end();
        walk("R4", 1'b0, 16'h0033, 1'b0, 1'b0, 12'h000, 4);
        clear_mem();
        put_head(8'h00);
        walk("R4", 1'b0, 16'h0000, 1'b0, 1'b0, 12'h000, 1);
    endtask

    task automatic t_low_bits();
        clear_mem();
        put_head(8'h43);
        put_std(12'h040, 8'h07, 8'h63);
        put_std(12'h060, 8'h09, 8'h00);
        walk("R3", 1'b0, 16'h0009, 1'b1, 1'b0, 12'h060, 3);
    endtask

    task automatic t_std_range();
        clear_mem();
        put_head(8'h40);
        put_std(12'h040, 8'h01, 8'h20);
        walk("R5", 1'b0, 16'h0002, 1'b0, 1'b1, 12'h000, 2);
        put_head(8'h10);
        walk("R5", 1'b0, 16'h0002, 1'b0, 1'b1, 12'h000, 1);
    endtask

    task automatic t_std_loop();
        clear_mem();
        put_head(8'h40);
        put_std(12'h040, 8'h01, 8'h50);
        put_std(12'h050, 8'h02, 8'h40);
        walk("R6", 1'b0, 16'h0077, 1'b0, 1'b1, 12'h000, 49);
    endtask

    task automatic t_ext();
        clear_mem();
        put_ext(12'h100, 16'h0001, 4'h1, 12'h148);
        put_ext(12'h148, 16'h1234, 4'hF, 12'h2A0);
        put_ext(12'h2A0, 16'h0019, 4'h2, 12'h000);
        walk("R2", 1'b1, 16'h1234, 1'b1, 1'b0, 12'h148, 2);
        walk("R2", 1'b1, 16'h0019, 1'b1, 1'b0, 12'h2A0, 3);
        walk("R2", 1'b1, 16'h0034, 1'b0, 1'b0, 12'h000, 3);
        clear_mem();
        walk("R4", 1'b1, 16'h0000, 1'b0, 1'b0, 12'h000, 1);
        put_ext(12'h100, 16'h0001, 4'h1, 12'h0C0);
        walk("R5", 1'b1, 16'h0002, 1'b0, 1'b1, 12'h000, 1);
    endtask

    task automatic t_ext_loop();
        clear_mem();
        put_ext(12'h100, 16'h0001, 4'h1, 12'h200);
        put_ext(12'h200, 16'h0002, 4'h1, 12'h100);
        walk("R6", 1'b1, 16'hBEEF, 1'b0, 1'b1, 12'h000, 960);
    endtask

    task automatic t_busy_start();
        int n;
        clear_mem();
        put_head(8'h40);
        put_std(12'h040, 8'h01, 8'h5C);
        put_std(12'h05C, 8'h05, 8'h70);
        put_std(12'h070, 8'h10, 8'h00);
        put_ext(12'h100, 16'h0010, 4'h1, 12'h000);
        reads = 0;
        pulse_start(1'b0, 16'h0010);
        repeat (3) @(negedge clk);
        cmd_start = 1'b1; cmd_ext = 1'b1; cmd_id = 16'h0010;
        @(negedge clk);
        cmd_start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R8", "found first walk", {31'h0, found}, 32'h1);
        check("R8", "offset from first walk", {20'h0, offset}, 32'h070);
        check("R8", "read count", reads, 4);
    endtask

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_find();
        t_std_end();
        t_low_bits();
        t_std_range();
        t_std_loop();
        t_ext();
        t_ext_loop();
        t_busy_start();
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule